// File: doc/BRIEF.md
# Configurable-Framing Serial Transmitter

This block drains bytes from an external transmit FIFO and sends each one as an asynchronous serial frame on a single output line. A free-running baud generator produces a tick every `divisor` reference clocks. Sixteen such ticks make one bit time, so the bit rate is the reference clock divided by sixteen times the divisor. With a 125 MHz reference and the reset divisor of 68, the rate is close to 115200 baud.

A 7-bit format word sets the frame shape. Bit 0 picks one or two stop bits. Bit 2 picks eight or seven data bits. Bits 6:4 pick the parity type: none, mark, space, even or odd. The transmitter copies the format word when it starts a frame, so a write made during a frame only applies to the next one. Each time it takes a byte from the FIFO it raises a one-cycle pop strobe. The FIFO uses this strobe to advance its read side, and an interrupt block can count it to track draining. A busy flag covers every frame from the start bit to the last stop bit.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset the line is high and busy is low. While busy is low the line stays high, and no byte is taken while `fifo_empty` is 1.
- R2: Every bit lasts exactly 16 × divisor clock cycles. The divisor register is 12 bits wide, resets to 68 and is loaded by `div_we`.
- R3: A frame begins with one low start bit. The data bits follow, least significant bit first.
- R4: Format bit 2 selects the data width: 0 sends eight data bits, 1 sends seven (byte bits 6:0). Its reset value is 0.
- R5: Format bit 0 selects the stop bits: 0 sends one high stop bit, 1 sends two. Its reset value is 1.
- R6: Format bits 6:4 select the parity bit, which follows the data bits. 0 sends no parity bit, 1 sends a constant 1, 2 sends a constant 0, 3 sends even parity over the data bits sent, and 4 sends odd parity. Codes 5 to 7 send no parity bit. The reset code is 3.
- R7: `tx_pop` is a one-cycle pulse, raised once for each byte taken and only while `fifo_empty` is 0. In the cycle after it, the start bit is on the line.
- R8: A format word written during a frame does not change that frame. It applies from the next frame on.
- R9: `tx_busy` is high from the first cycle of the start bit through the last cycle of the last stop bit. It falls when the frame ends if no byte is waiting.
- R10: If a byte is waiting when the last stop bit ends, its start bit follows at once, with no idle bit between the frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write strobe for the format word |
| cfg_wdata | input | 7 | Format word: bit 0 stop count, bit 2 data width, bits 6:4 parity code |
| div_we | input | 1 | Write strobe for the baud divisor |
| div_wdata | input | 12 | New baud divisor |
| fifo_empty | input | 1 | Transmit FIFO holds no byte |
| fifo_data | input | 8 | Byte at the head of the transmit FIFO |
| tx_line | output | 1 | Serial output; high when idle |
| tx_busy | output | 1 | A frame is on the line |
| tx_pop | output | 1 | One-cycle strobe: the head byte was taken |

## Verification
The assertions check four things on every cycle. The line is high whenever the block is idle. A pop happens only when the FIFO has data, lasts a single cycle, and is followed at once by a low start bit with busy high. The latched frame format never changes while a frame is in progress. Bit timing, LSB-first order, the parity value for each of the eight codes, the stop-bit count, back-to-back spacing, and deferral of a format written mid-frame can only be shown by the bench. It decodes each frame at bit centres and compares it with a frame it builds from the format word and the byte.

// File: rtl/uart_frame_pkg.sv
package uart_frame_pkg;

    localparam int FMT_W = 7;

    // parity codes carried in format bits 6:4
    localparam logic [2:0] PAR_NONE  = 3'd0;
    localparam logic [2:0] PAR_MARK  = 3'd1;
    localparam logic [2:0] PAR_SPACE = 3'd2;
    localparam logic [2:0] PAR_EVEN  = 3'd3;
    localparam logic [2:0] PAR_ODD   = 3'd4;

    // reset format: two stop bits, eight data bits, even parity
    localparam logic [FMT_W-1:0] FMT_RESET = 7'h31;

    typedef struct packed {
        logic       two_stop;
        logic       seven_bits;
        logic [2:0] par;
    } frame_fmt_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } tx_state_e;

    function automatic frame_fmt_t decode_fmt(input logic [FMT_W-1:0] w);
        frame_fmt_t f;
        f.two_stop   = w[0];
        f.seven_bits = w[2];
        f.par        = w[6:4];
        return f;
    endfunction

    function automatic logic par_active(input logic [2:0] code);
        return (code >= PAR_MARK) && (code <= PAR_ODD);
    endfunction

    // acc: XOR of the data bits already sent
    function automatic logic par_bit(input logic [2:0] code, input logic acc);
        logic b;
        case (code)
            PAR_MARK:  b = 1'b1;
            PAR_SPACE: b = 1'b0;
            PAR_EVEN:  b = acc;
            default:   b = ~acc;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/uart_fmt_regs.sv
module uart_fmt_regs
    import uart_frame_pkg::*;
#(
    parameter int DIV_W     = 12,
    parameter int DIV_RESET = 68
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [FMT_W-1:0] cfg_wdata,
    input  logic             div_we,
    input  logic [DIV_W-1:0] div_wdata,
    output frame_fmt_t       fmt,
    output logic [DIV_W-1:0] divisor
);

    typedef struct packed {
        frame_fmt_t       fmt;
        logic [DIV_W-1:0] div;
    } regs_t;

    regs_t q, d;

    always_comb begin
        d = q;
        if (cfg_we) d.fmt = decode_fmt(cfg_wdata);
        if (div_we) d.div = div_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.fmt <= decode_fmt(FMT_RESET);
            q.div <= DIV_W'(DIV_RESET);
        end else begin
            q <= d;
        end
    end

    assign fmt     = q.fmt;
    assign divisor = q.div;

endmodule

// File: rtl/uart_baud_gen.sv
module uart_baud_gen #(
    parameter int DIV_W = 12,
    parameter int OSR   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] divisor,
    output logic             bit_tick
);

    localparam int OS_W = $clog2(OSR);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic [OS_W-1:0]  os;
    } baud_t;

    baud_t q, d;
    logic  os_tick;
    logic [DIV_W-1:0] limit;

    always_comb begin
        // a divisor of zero runs as one
        limit   = (divisor == '0) ? '0 : divisor - 1'b1;
        os_tick = (q.cnt >= limit);
        d       = q;
        if (os_tick) begin
            d.cnt = '0;
            d.os  = (q.os == OS_W'(OSR - 1)) ? '0 : q.os + 1'b1;
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign bit_tick = os_tick && (q.os == OS_W'(OSR - 1));

endmodule

// File: rtl/uart_tx_seq.sv
module uart_tx_seq
    import uart_frame_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  frame_fmt_t        fmt_in,
    input  logic              fifo_empty,
    input  logic [DATA_W-1:0] fifo_data,
    output logic              pop,
    output logic              line,
    output logic              busy,
    output frame_fmt_t        frame_fmt
);

    localparam int CNT_W = $clog2(DATA_W + 1);

    typedef struct packed {
        tx_state_e         st;
        logic [DATA_W-1:0] shreg;
        logic [CNT_W-1:0]  cnt;
        frame_fmt_t        fmt;
        logic              acc;
        logic              line;
    } seq_t;

    seq_t q, d;
    logic [CNT_W-1:0] last_idx;

    always_comb begin
        d        = q;
        pop      = 1'b0;
        last_idx = q.fmt.seven_bits ? CNT_W'(DATA_W - 2) : CNT_W'(DATA_W - 1);
        if (bit_tick) begin
            unique case (q.st)
                ST_IDLE: begin
                    if (!fifo_empty) begin
                        pop     = 1'b1;
                        d.st    = ST_START;
                        d.shreg = fifo_data;
                        d.fmt   = fmt_in;
                        d.acc   = 1'b0;
                        d.line  = 1'b0;
                    end
                end
                ST_START: begin
                    d.st    = ST_DATA;
                    d.line  = q.shreg[0];
                    d.acc   = q.shreg[0];
                    d.shreg = q.shreg >> 1;
                    d.cnt   = '0;
                end
                ST_DATA: begin
                    if (q.cnt == last_idx) begin
                        d.cnt = '0;
                        if (par_active(q.fmt.par)) begin
                            d.st   = ST_PARITY;
                            d.line = par_bit(q.fmt.par, q.acc);
                        end else begin
                            d.st   = ST_STOP;
                            d.line = 1'b1;
                        end
                    end else begin
                        d.line  = q.shreg[0];
                        d.acc   = q.acc ^ q.shreg[0];
                        d.shreg = q.shreg >> 1;
                        d.cnt   = q.cnt + 1'b1;
                    end
                end
                ST_PARITY: begin
                    d.st   = ST_STOP;
                    d.line = 1'b1;
                    d.cnt  = '0;
                end
                ST_STOP: begin
                    if (q.fmt.two_stop && (q.cnt == '0)) begin
                        d.cnt = q.cnt + 1'b1;
                    end else if (!fifo_empty) begin
                        pop     = 1'b1;
                        d.st    = ST_START;
                        d.shreg = fifo_data;
                        d.fmt   = fmt_in;
                        d.acc   = 1'b0;
                        d.line  = 1'b0;
                    end else begin
                        d.st   = ST_IDLE;
                        d.line = 1'b1;
                    end
                end
                default: d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st    <= ST_IDLE;
            q.shreg <= '0;
            q.cnt   <= '0;
            q.fmt   <= decode_fmt(FMT_RESET);
            q.acc   <= 1'b0;
            q.line  <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign line      = q.line;
    assign busy      = (q.st != ST_IDLE);
    assign frame_fmt = q.fmt;

endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
    import uart_frame_pkg::*;
#(
    parameter int DIV_W     = 12,
    parameter int DIV_RESET = 68,
    parameter int OSR       = 16,
    parameter int DATA_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [FMT_W-1:0]  cfg_wdata,
    input  logic              div_we,
    input  logic [DIV_W-1:0]  div_wdata,
    input  logic              fifo_empty,
    input  logic [DATA_W-1:0] fifo_data,
    output logic              tx_line,
    output logic              tx_busy,
    output logic              tx_pop
);

    frame_fmt_t       reg_fmt;
    frame_fmt_t       active_fmt;
    logic [DIV_W-1:0] divisor;
    logic             bit_tick;

    uart_fmt_regs #(.DIV_W(DIV_W), .DIV_RESET(DIV_RESET)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .div_we    (div_we),
        .div_wdata (div_wdata),
        .fmt       (reg_fmt),
        .divisor   (divisor)
    );

    uart_baud_gen #(.DIV_W(DIV_W), .OSR(OSR)) u_baud (
        .clk      (clk),
        .rst_n    (rst_n),
        .divisor  (divisor),
        .bit_tick (bit_tick)
    );

    uart_tx_seq #(.DATA_W(DATA_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_tick   (bit_tick),
        .fmt_in     (reg_fmt),
        .fifo_empty (fifo_empty),
        .fifo_data  (fifo_data),
        .pop        (tx_pop),
        .line       (tx_line),
        .busy       (tx_busy),
        .frame_fmt  (active_fmt)
    );

endmodule

// File: rtl/uart_frame_tx_chk.sv
module uart_frame_tx_chk
    import uart_frame_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       tx_line,
    input logic       tx_busy,
    input logic       tx_pop,
    input logic       fifo_empty,
    input frame_fmt_t active_fmt
);

    // R1
    idle_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_busy |-> tx_line);

    // R7
    pop_needs_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop |-> !fifo_empty);

    // R7
    pop_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop |=> !tx_pop);

    // R3
    start_after_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop |=> (tx_busy && !tx_line));

    // R8
    fmt_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_busy && $past(tx_busy) && !$past(tx_pop)) |-> $stable(active_fmt));

endmodule

bind uart_frame_tx uart_frame_tx_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_line    (tx_line),
    .tx_busy    (tx_busy),
    .tx_pop     (tx_pop),
    .fifo_empty (fifo_empty),
    .active_fmt (active_fmt)
);

// File: tb/uart_frame_tx_test.sv
module uart_frame_tx_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [6:0]  cfg_wdata = '0;
    logic        div_we = 1'b0;
    logic [11:0] div_wdata = '0;
    logic        fifo_empty;
    logic [7:0]  fifo_data;
    logic        tx_line, tx_busy, tx_pop;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int pops   = 0;
    int cur_div = 68;

    logic [7:0] q_mem [0:63];
    int wr_i = 0;
    int rd_i = 0;

    always #10 clk = ~clk;

    uart_frame_tx uut (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .div_we(div_we), .div_wdata(div_wdata),
        .fifo_empty(fifo_empty), .fifo_data(fifo_data),
        .tx_line(tx_line), .tx_busy(tx_busy), .tx_pop(tx_pop)
    );

    assign fifo_empty = (wr_i == rd_i);
    assign fifo_data  = q_mem[rd_i % 64];

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (tx_pop && rst_n) begin
            rd_i <= rd_i + 1;
            pops <= pops + 1;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic push(input logic [7:0] b);
        @(negedge clk);
        q_mem[wr_i % 64] = b;
        wr_i = wr_i + 1;
    endtask

    task automatic set_fmt(input logic [6:0] w);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = w;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic set_div(input int v);
        @(negedge clk);
        div_we = 1'b1; div_wdata = 12'(v);
        @(negedge clk);
        div_we = 1'b0;
        cur_div = v;
    endtask

    // expected frame built from the requirements: bits in send order
    function automatic void build_frame(input logic [6:0] f, input logic [7:0] b,
                                        output logic [11:0] bits, output int len,
                                        output int par_pos, output int stop_pos);
        int nb;
        logic acc;
        logic [2:0] pc;
        bits = '1;
        nb = f[2] ? 7 : 8;
        pc = f[6:4];
        bits[0] = 1'b0;
        acc = 1'b0;
        for (int i = 0; i < nb; i++) begin
            bits[1+i] = b[i];
            acc ^= b[i];
        end
        len = 1 + nb;
        par_pos = -1;
        if (pc >= 3'd1 && pc <= 3'd4) begin
            par_pos = len;
            case (pc)
                3'd1: bits[len] = 1'b1;
                3'd2: bits[len] = 1'b0;
                3'd3: bits[len] = acc;
                default: bits[len] = ~acc;
            endcase
            len++;
        end
        stop_pos = len;
        len += f[0] ? 2 : 1;
    endfunction

    // decode one frame at bit centres; returns the cycle of start detection
    task automatic recv(input logic [6:0] f, input logic [7:0] b, output int t0);
        logic [11:0] eb;
        int len, pp, sp, bt, guard;
        string tag;
        build_frame(f, b, eb, len, pp, sp);
        bt = 16 * cur_div;
        guard = 0;
        @(negedge clk);
        while (tx_line !== 1'b0 && guard < 40 * bt) begin
            @(negedge clk);
            guard++;
        end
        check(tx_line === 1'b0, "R7 frame start seen", tx_line, 0);
        t0 = cyc;
        repeat (bt / 2) @(negedge clk);
        for (int k = 0; k < len; k++) begin
            if (k == 0)            tag = "R3 start bit";
            else if (k == pp)      tag = "R6 parity bit";
            else if (k >= sp)      tag = "R5 stop bit";
            else                   tag = "R4 data bit";
            check(tx_line === eb[k], tag, tx_line, eb[k]);
            check(tx_busy === 1'b1, "R9 busy in frame", tx_busy, 1);
            if (k != len - 1) repeat (bt) @(negedge clk);
        end
    endtask

    task automatic expect_idle_after(input string req);
        repeat (8 * cur_div + 3) @(negedge clk);
        check(tx_busy === 1'b0, req, tx_busy, 0);
        check(tx_line === 1'b1, "R1 idle line high", tx_line, 1);
    endtask

    initial begin : watchdog
        wait (cyc >= 190000);
        fails++;
        checks++;
        $display("FAIL watchdog expired at cycle %0d actual=1 expected=0", cyc);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin : main
        int t0, t1, t2, len, pp, sp, p0;
        logic [11:0] eb;
        logic [6:0] f;
        logic [7:0] b;
        void'($urandom(32'h5eed_1234));

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(tx_line === 1'b1, "R1 reset line", tx_line, 1);
        check(tx_busy === 1'b0, "R1 reset busy", tx_busy, 0);
        repeat (3000) @(negedge clk);
        check(pops == 0, "R1 no pop while empty", pops, 0);
        check(tx_busy === 1'b0, "R1 stays idle", tx_busy, 0);

        // R2 R4 R5 R6 reset format and divisor: 8 data, even parity, 2 stop, 68
        push(8'hA5);
        recv(7'h31, 8'hA5, t0);
        expect_idle_after("R9 busy falls at end");
        check(pops == 1, "R7 one pop per byte", pops, 1);

        // R2 bit time at a small divisor: back-to-back spacing equals len*16*div
        set_div(2);
        set_fmt(7'h00);
        push(8'h3C); push(8'hC3); push(8'h81);
        p0 = pops;
        recv(7'h00, 8'h3C, t0);
        recv(7'h00, 8'hC3, t1);
        recv(7'h00, 8'h81, t2);
        check(t1 - t0 == 10 * 32, "R10 no gap between frames", t1 - t0, 320);
        check(t2 - t1 == 10 * 32, "R2 bit time 16*div", t2 - t1, 320);
        expect_idle_after("R9 busy falls after last frame");
        check(pops - p0 == 3, "R7 pops match bytes", pops - p0, 3);

        // R6 every parity code, in both widths and both stop counts
        for (int c = 0; c < 8; c++) begin
            for (int w = 0; w < 2; w++) begin
                f = {3'(c), 1'b0, 1'(w), 1'b0, 1'(c & 1)};
                set_fmt(f);
                push(8'h6B);
                recv(f, 8'h6B, t0);
                expect_idle_after("R9 idle between directed frames");
            end
        end

        // R8 format written mid-frame applies only to the next frame
        set_fmt(7'h00);
        push(8'h96);
        fork
            recv(7'h00, 8'h96, t0);
            begin
                repeat (3 * 32) @(negedge clk);
                cfg_we = 1'b1; cfg_wdata = 7'h45;
                @(negedge clk);
                cfg_we = 1'b0;
            end
        join
        expect_idle_after("R8 old frame ended on old format");
        push(8'h96);
        recv(7'h45, 8'h96, t0);
        expect_idle_after("R8 new format used next");

        // random frames, format and divisor written while idle
        for (int n = 0; n < 30; n++) begin
            set_div(1 + ($urandom % 3));
            f = 7'($urandom);
            b = 8'($urandom);
            set_fmt(f);
            push(b);
            recv(f, b, t0);
            expect_idle_after("R9 idle after random frame");
        end
        build_frame(7'h31, 8'h00, eb, len, pp, sp);
        check(len == 12, "R5 R6 frame length model", len, 12);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule